// File: doc/BRIEF.md
# Octaword Load-and-Replicate Unit

This block carries out a predicated vector load. It fetches one 32-byte chunk from memory and spreads that chunk across a destination vector register whose length is chosen at run time. A request supplies four things: a base address, an address mode, an element size code and a byte-granular predicate. The address mode is either a scaled index register value or a 4-bit signed immediate. The request also carries the current vector length in bytes.

The block forms the effective address and issues a single 32-byte read on a valid/ready memory port. It zeroes the inactive elements of the returned chunk. It then copies the chunk into every complete 32-byte slot of the vector and writes zero to everything above the last complete slot.

A request that cannot execute returns a one-cycle result pulse with an undefined-instruction flag and touches no memory. This happens in two cases: the vector is shorter than 32 bytes, or the scalar-plus-scalar mode names index register 31. The unit handles one load at a time.

Top module: `octa_bcast_ld`

## Requirements
- R1: After reset the unit is idle: `req_ready` is 1 and `mem_req_valid`, `mem_rsp_ready` and `res_valid` are 0.
- R2: A request with `req_vl` below 32 gives `res_valid`=1 with `res_undef`=1 in the cycle after acceptance. In that cycle `res_data` is all zero, and no memory request is issued.
- R3: A request with `req_mode`=0 (scalar plus scalar) and `req_idx_reg`=31 is rejected as in R2. With `req_mode`=1, the value of `req_idx_reg` has no effect.
- R4: With `req_mode`=0 the read address is `req_base + (req_index << req_esize)`, modulo 2^64.
- R5: With `req_mode`=1 the read address is `req_base + sext(req_imm)*32`, modulo 2^64. The immediate is 4 bits, two's complement.
- R6: Element bytes are 2^`req_esize` (0=1, 1=2, 2=4, 3=8). Result bytes 0..31 are the memory chunk, except that an element whose lowest byte has a clear predicate bit reads as zero.
- R7: Predicate bits 32 and above have no effect on the result.
- R8: Every byte b with 32 <= b < 32*floor(`req_vl`/32) equals result byte b mod 32.
- R9: Every result byte at or above 32*floor(`req_vl`/32) is zero. For example, bytes 32..47 are zero when `req_vl` is 48.
- R10: `res_valid` rises, with `res_undef`=0, exactly one cycle after the memory response is accepted, and it lasts one cycle.
- R11: `req_ready` is 0 from request acceptance until the result pulse ends. Exactly one memory request is issued per valid load, and its address is held until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_mode | input | 1 | 0 = base plus scaled index, 1 = base plus immediate |
| req_base | input | 64 | Base address |
| req_index | input | 64 | Index register value (mode 0) |
| req_idx_reg | input | 5 | Index register number (mode 0; 31 is invalid) |
| req_imm | input | 4 | Signed immediate in 32-byte units (mode 1) |
| req_esize | input | 2 | log2 of element bytes |
| req_pred | input | 256 | Byte-granular predicate |
| req_vl | input | 9 | Vector length in bytes |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 64 | Byte address of the 32-byte read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Unit takes the read data |
| mem_rsp_data | input | 256 | 32 bytes of read data, byte 0 in bits 7:0 |
| res_valid | output | 1 | One-cycle result pulse |
| res_undef | output | 1 | Request rejected as undefined (valid with res_valid) |
| res_data | output | 2048 | Destination vector, byte 0 in bits 7:0 |

## Verification
The assertions assume that `req_vl` is a multiple of 16 between 16 and 256. They also assume the memory model never raises `mem_rsp_valid` before its read request has been taken, and that it returns exactly one response per request. The bench keeps to these assumptions. It sweeps every legal vector length with every element size in both address modes, and its memory model answers only after it has seen the request handshake. Random base, index, predicate and data values stress address wrap-around and the masking. Directed cases exercise the two rejection paths.

// File: rtl/obl_pkg.sv
package obl_pkg;
  localparam int unsigned CHUNK_BYTES = 32;
  localparam int unsigned CHUNK_SH    = 5;
  localparam int unsigned CHUNK_W     = CHUNK_BYTES * 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_OUT  = 2'd3
  } obl_state_e;

  localparam logic MODE_REG = 1'b0;
  localparam logic MODE_IMM = 1'b1;
endpackage

// File: rtl/obl_rst_sync.sv
module obl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sn = s1_q;
endmodule

// File: rtl/obl_agen.sv
module obl_agen #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IMM_W  = 4,
  parameter int unsigned ES_W   = 2
) (
  input  logic              mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ES_W-1:0]   esize,
  output logic [ADDR_W-1:0] addr
);
  import obl_pkg::*;

  localparam int unsigned EXT_W = ADDR_W - IMM_W - CHUNK_SH;

  logic [ADDR_W-1:0] scaled_idx;
  logic [ADDR_W-1:0] imm_off;

  assign scaled_idx = index << esize;
  assign imm_off    = {{EXT_W{imm[IMM_W-1]}}, imm, {CHUNK_SH{1'b0}}};
  assign addr       = base + ((mode == MODE_IMM) ? imm_off : scaled_idx);
endmodule

// File: rtl/obl_pmask.sv
module obl_pmask #(
  parameter int unsigned NBYTES = 32,
  parameter int unsigned ES_W   = 2
) (
  input  logic [NBYTES*8-1:0] data,
  input  logic [NBYTES-1:0]   pred,
  input  logic [ES_W-1:0]     esize,
  output logic [NBYTES*8-1:0] masked
);
  localparam int unsigned IDX_W = $clog2(NBYTES);

  logic [IDX_W-1:0] low_mask;

  assign low_mask = IDX_W'((32'd1 << esize) - 32'd1);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [IDX_W-1:0] elem_lo;
    assign elem_lo = IDX_W'(b) & ~low_mask;
    assign masked[b*8 +: 8] = pred[elem_lo] ? data[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/obl_repl.sv
module obl_repl #(
  parameter int unsigned NBYTES = 32,
  parameter int unsigned MAX_VL = 256,
  parameter int unsigned VL_W   = 9
) (
  input  logic [NBYTES*8-1:0] chunk,
  input  logic [VL_W-1:0]     vl,
  output logic [MAX_VL*8-1:0] vec
);
  localparam int unsigned SLOTS  = MAX_VL / NBYTES;
  localparam int unsigned SLOT_W = NBYTES * 8;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic full;
    assign full = (32'(vl) >= (s + 1) * NBYTES);
    assign vec[s*SLOT_W +: SLOT_W] = full ? chunk : '0;
  end
endmodule

// File: rtl/octa_bcast_ld.sv
module octa_bcast_ld #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned MAX_VL = 256,
  parameter int unsigned IMM_W  = 4,
  parameter int unsigned ES_W   = 2,
  parameter int unsigned REG_W  = 5,
  localparam int unsigned VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_mode,
  input  logic [ADDR_W-1:0]   req_base,
  input  logic [ADDR_W-1:0]   req_index,
  input  logic [REG_W-1:0]    req_idx_reg,
  input  logic [IMM_W-1:0]    req_imm,
  input  logic [ES_W-1:0]     req_esize,
  input  logic [MAX_VL-1:0]   req_pred,
  input  logic [VL_W-1:0]     req_vl,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ADDR_W-1:0]   mem_req_addr,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [255:0]        mem_rsp_data,
  output logic                res_valid,
  output logic                res_undef,
  output logic [MAX_VL*8-1:0] res_data
);
  import obl_pkg::*;

  logic rst_sn;
  obl_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  obl_state_e state_q, state_d;
  logic req_fire, mreq_fire, rsp_fire, bad_req;

  logic [ADDR_W-1:0]      addr_q, addr_c;
  logic [CHUNK_BYTES-1:0] pred_q;
  logic [ES_W-1:0]        esize_q;
  logic [VL_W-1:0]        vl_q;
  logic                   undef_q;
  logic [CHUNK_W-1:0]     chunk_q, chunk_m;
  logic                   pred_hi_unused;

  assign pred_hi_unused = ^req_pred[MAX_VL-1:CHUNK_BYTES];

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ADDR);
  assign mem_rsp_ready = (state_q == ST_WAIT);
  assign res_valid     = (state_q == ST_OUT);
  assign res_undef     = res_valid & undef_q;
  assign mem_req_addr  = addr_q;

  assign req_fire  = req_valid & req_ready;
  assign mreq_fire = mem_req_valid & mem_req_ready;
  assign rsp_fire  = mem_rsp_valid & mem_rsp_ready;
  assign bad_req   = (req_vl < VL_W'(CHUNK_BYTES)) ||
                     ((req_mode == MODE_REG) && (req_idx_reg == {REG_W{1'b1}}));

  obl_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .ES_W(ES_W)) i_agen (
    .mode(req_mode), .base(req_base), .index(req_index),
    .imm(req_imm), .esize(req_esize), .addr(addr_c)
  );

  obl_pmask #(.NBYTES(CHUNK_BYTES), .ES_W(ES_W)) i_pmask (
    .data(mem_rsp_data), .pred(pred_q), .esize(esize_q), .masked(chunk_m)
  );

  obl_repl #(.NBYTES(CHUNK_BYTES), .MAX_VL(MAX_VL), .VL_W(VL_W)) i_repl (
    .chunk(chunk_q), .vl(vl_q), .vec(res_data)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_fire)  state_d = bad_req ? ST_OUT : ST_ADDR;
      ST_ADDR: if (mreq_fire) state_d = ST_WAIT;
      ST_WAIT: if (rsp_fire)  state_d = ST_OUT;
      ST_OUT:                 state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      addr_q  <= '0;
      pred_q  <= '0;
      esize_q <= '0;
      vl_q    <= '0;
      undef_q <= 1'b0;
    end else if (req_fire) begin
      addr_q  <= addr_c;
      pred_q  <= req_pred[CHUNK_BYTES-1:0];
      esize_q <= req_esize;
      vl_q    <= req_vl;
      undef_q <= bad_req;
    end
  end

  // chunk register: cleared on acceptance, loaded on response
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)       chunk_q <= '0;
    else if (req_fire) chunk_q <= '0;
    else if (rsp_fire) chunk_q <= chunk_m;
  end

  a_r10_valid_after_rsp: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_fire |=> (res_valid && !res_undef));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    res_valid |=> !res_valid);
  a_r11_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req_valid || mem_rsp_ready || res_valid) |-> !req_ready);
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r2_undef_no_mem: assert property (@(posedge clk) disable iff (!rst_sn)
    res_undef |-> $past(req_valid && req_ready));
  a_r2_undef_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    res_undef |-> (res_data == '0));
endmodule

// File: tb/test_octa_bcast_ld.sv
module test_octa_bcast_ld;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_mode;
  logic [63:0] req_base, req_index;
  logic [4:0] req_idx_reg;
  logic [3:0] req_imm;
  logic [1:0] req_esize;
  logic [255:0] req_pred;
  logic [8:0] req_vl;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [63:0] mem_req_addr;
  logic [255:0] mem_rsp_data;
  logic res_valid, res_undef;
  logic [2047:0] res_data;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  octa_bcast_ld i_octa_bcast_ld (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // byte regions: 0 = low chunk, 1 = full copies, 2 = zero tail
  task automatic chk_region(input int region, input string tag, input int vl, input int es,
                            input logic [255:0] pred, input logic [255:0] data);
    int lo, hi, floor32, bad;
    logic [7:0] a, e;
    floor32 = (vl / 32) * 32;
    lo = (region == 0) ? 0 : (region == 1) ? 32 : floor32;
    hi = (region == 0) ? 32 : (region == 1) ? floor32 : 256;
    bad = -1; a = 0; e = 0;
    for (int b = lo; b < hi; b++) begin
      int src, eb;
      logic [7:0] ex;
      src = b % 32;
      eb  = src - (src % (1 << es));
      ex  = (b < floor32 && pred[eb]) ? data[src*8 +: 8] : 8'h00;
      if (bad < 0 && res_data[b*8 +: 8] !== ex) begin
        bad = b; a = res_data[b*8 +: 8]; e = ex;
      end
    end
    chk(bad < 0, tag, {56'h0, a}, {56'h0, e});
  endtask

  task automatic do_load(input logic mode, input int vl, input int es,
                         input logic [3:0] imm, input logic [4:0] ireg);
    logic [63:0] base, idx, exp_addr;
    logic [255:0] pred, data;
    bit undef_exp;
    int gap;
    base = {$urandom, $urandom};
    idx  = {$urandom, $urandom};
    pred = rnd256();
    data = rnd256();
    gap  = (vl / 16 + es) % 3;
    undef_exp = (vl < 32) || (mode == 1'b0 && ireg == 5'd31);
    exp_addr = (mode == 1'b0) ? base + (idx << es)
                              : base + ({{60{imm[3]}}, imm} * 64'd32);
    @(negedge clk);
    req_valid = 1; req_mode = mode; req_base = base; req_index = idx;
    req_idx_reg = ireg; req_imm = imm; req_esize = 2'(es); req_pred = pred;
    req_vl = 9'(vl);
    chk(req_ready === 1'b1, "R11 idle ready", {63'h0, req_ready}, 64'h1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    req_pred = rnd256();
    if (undef_exp) begin
      chk(res_valid && res_undef && !mem_req_valid, (vl < 32) ? "R2 undef" : "R3 undef",
          {61'h0, res_valid, res_undef, mem_req_valid}, 64'h6);
      chk(res_data === '0, "R2 undef data zero", res_data[63:0], 64'h0);
      @(negedge clk);
      chk(!res_valid && req_ready && !mem_req_valid, "R2 no memory access",
          {61'h0, res_valid, req_ready, mem_req_valid}, 64'h2);
      return;
    end
    chk(mem_req_valid && mem_req_addr === exp_addr, mode ? "R5 addr" : "R4 addr",
        mem_req_addr, exp_addr);
    chk(!req_ready, "R11 busy", {63'h0, req_ready}, 64'h0);
    repeat (gap) @(negedge clk);
    chk(mem_req_valid && mem_req_addr === exp_addr, "R11 addr held", mem_req_addr, exp_addr);
    mem_req_ready = 1;
    @(posedge clk);
    @(negedge clk);
    mem_req_ready = 0;
    chk(!mem_req_valid, "R11 single request", {63'h0, mem_req_valid}, 64'h0);
    repeat (gap) @(negedge clk);
    chk(!res_valid, "R10 no early result", {63'h0, res_valid}, 64'h0);
    mem_rsp_valid = 1; mem_rsp_data = data;
    @(posedge clk);
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_data = rnd256();
    chk(res_valid && !res_undef, "R10 result pulse", {62'h0, res_valid, res_undef}, 64'h2);
    chk_region(0, "R6 R7 low chunk", vl, es, pred, data);
    chk_region(1, "R8 copies", vl, es, pred, data);
    chk_region(2, "R9 zero tail", vl, es, pred, data);
    @(negedge clk);
    chk(!res_valid && req_ready, "R10 pulse ends", {62'h0, res_valid, req_ready}, 64'h1);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_mode = 0; req_base = 0; req_index = 0;
    req_idx_reg = 0; req_imm = 0; req_esize = 0; req_pred = 0; req_vl = 9'd32;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(req_ready && !mem_req_valid && !mem_rsp_ready && !res_valid, "R1 reset state",
        {60'h0, req_ready, mem_req_valid, mem_rsp_ready, res_valid}, 64'h8);

    for (int m = 0; m < 2; m++)
      for (int v = 1; v <= 16; v++)
        for (int es = 0; es < 4; es++)
          do_load(1'(m), v * 16, es, 4'((v + es * 5) % 16),
                  (m == 1) ? 5'd31 : 5'($urandom % 31));

    do_load(1'b0, 64, 0, 4'd0, 5'd31);   // R3 rejected
    do_load(1'b0, 256, 3, 4'd0, 5'd31);  // R3 rejected
    do_load(1'b1, 96, 2, 4'd8, 5'd31);   // R3 ignored in immediate mode, R5 most negative
    do_load(1'b1, 16, 1, 4'd7, 5'd0);    // R2 short vector
    do_load(1'b1, 48, 0, 4'd7, 5'd0);    // R9 48-byte tail

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule